// File: doc/BRIEF.md
# Sampled-PC Debug Register Slave

This block is the external debug register window of a processor core, reduced to the part that supports sample-based profiling. A profiler on an APB-style bus reads a program-counter sample register. That read returns the core's live PC and, at the same clock edge, captures the core's context ID, its virtual-machine/state word and the upper 32 bits of the PC. Later reads of those companion registers therefore match the sampled PC, even if the core has moved on.

The window also holds an OS lock, a power request control register that drives a power-up request to an external power controller, a status register that reports power and lock conditions, and two read-only identification registers. A sample read returns all ones while the core is halted for debug or sampling is prohibited. Sample reads return zero while the core is unpowered or double-locked. In both of these cases nothing is captured. Every access finishes in its access phase with no wait states.

Top module: `pcsamp_dbg_regs`

## Requirements
- R1: After reset the power request control register reads 0, `pwr_up_req` is 0, the OS lock is set (status bit 5 = 1), and the captured context, VM/state and PC-high registers read 0.
- R2: A read of offset 0x0A0 while permitted (`core_pwr_good`=1, `core_dlock`=0) and not prohibited returns `core_pc[31:0]` in the same access cycle.
- R3: Such a read captures `core_pc[63:32]` (offset 0x0AC), `core_ctxid` (0x0A4) and `core_vmstate` (0x0A8) at its completing edge. These registers change on no other event.
- R4: A read of 0x0A0 while permitted but with `core_prohibit`=1 returns 0xFFFFFFFF and captures nothing.
- R5: While not permitted, reads of 0x0A0, 0x0A4, 0x0A8 and 0x0AC return 0, and a read of 0x0A0 captures nothing.
- R6: At offset 0x310 only bit 3 (power-up request) and bit 0 (no power-down request) are writable. The other bits read 0. `pwr_up_req` is bit 3 OR bit 0, valid from the cycle after the write.
- R7: Offset 0x314 reads bit 0 = `core_pwr_good`, bit 5 = OS lock, bit 6 = `core_dlock`, and 0 elsewhere. It is read-only.
- R8: A write of zero to 0x300 clears the OS lock. A write with bit 0 set sets it. Offset 0x300 reads as 0.
- R9: Offset 0xFC8 reads `SAMPLE_MODE` in bits 3:0 (1 = PC only, 2 = PC and context, 3 = full). Offset 0xFC4 reads `PC_OFFSET_MODE` in bits 3:0. Writes to either have no effect.
- R10: The context register reads 0 when `SAMPLE_MODE` < 2, and the VM/state register reads 0 when `SAMPLE_MODE` < 3. The PC-high register is captured in every mode.
- R11: `pready` is always 1, and reads of unmapped offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | ADDR_W | Byte offset |
| pwdata | input | DATA_W | Write data |
| prdata | output | DATA_W | Read data, valid in the access phase |
| pready | output | 1 | Always 1 |
| core_pc | input | 2*DATA_W | Live program counter |
| core_ctxid | input | DATA_W | Live context ID |
| core_vmstate | input | DATA_W | Live security/level/width/VMID word |
| core_prohibit | input | 1 | Debug state or sampling prohibited |
| core_pwr_good | input | 1 | Core power domain up (synchronous) |
| core_dlock | input | 1 | OS double lock set |
| pwr_up_req | output | 1 | Request to the power controller |

## Verification
Read data is combinational and is sampled in the access phase, one cycle after the setup phase and before the completing edge. Captured companion values, register writes and `pwr_up_req` take effect on that completing edge. The bench checks them with a following access or after the edge. Core inputs are held steady across each transfer, so the bench model captures exactly the values the design sees. A second instance built with PC-only support is read alongside the first to cover the mode gating.

// File: rtl/pcsamp_dbg_regs.sv
module pcsamp_dbg_regs #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [3:0] SAMPLE_MODE = 4'd3,
  parameter logic [3:0] PC_OFFSET_MODE = 4'd1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  psel,
  input  logic                  penable,
  input  logic                  pwrite,
  input  logic [ADDR_W-1:0]     paddr,
  input  logic [DATA_W-1:0]     pwdata,
  output logic [DATA_W-1:0]     prdata,
  output logic                  pready,
  input  logic [2*DATA_W-1:0]   core_pc,
  input  logic [DATA_W-1:0]     core_ctxid,
  input  logic [DATA_W-1:0]     core_vmstate,
  input  logic                  core_prohibit,
  input  logic                  core_pwr_good,
  input  logic                  core_dlock,
  output logic                  pwr_up_req
);
  localparam logic [ADDR_W-1:0] A_PCLO  = ADDR_W'(12'h0A0);
  localparam logic [ADDR_W-1:0] A_CTX   = ADDR_W'(12'h0A4);
  localparam logic [ADDR_W-1:0] A_VM    = ADDR_W'(12'h0A8);
  localparam logic [ADDR_W-1:0] A_PCHI  = ADDR_W'(12'h0AC);
  localparam logic [ADDR_W-1:0] A_OSL   = ADDR_W'(12'h300);
  localparam logic [ADDR_W-1:0] A_PCTL  = ADDR_W'(12'h310);
  localparam logic [ADDR_W-1:0] A_PSTAT = ADDR_W'(12'h314);
  localparam logic [ADDR_W-1:0] A_ID1   = ADDR_W'(12'hFC4);
  localparam logic [ADDR_W-1:0] A_ID0   = ADDR_W'(12'hFC8);
  localparam bit HAS_CTX = SAMPLE_MODE >= 4'd2;
  localparam bit HAS_VM  = SAMPLE_MODE == 4'd3;

  logic [DATA_W-1:0] hi_q, ctx_q, vm_q;
  logic              up_q, npd_q, oslk_q;

  wire rd_en   = psel & penable & ~pwrite;
  wire wr_en   = psel & penable & pwrite;
  wire allowed = core_pwr_good & ~core_dlock;
  wire is_smp  = (paddr == A_PCLO) | (paddr == A_CTX) | (paddr == A_VM) | (paddr == A_PCHI);
  wire capture = rd_en & (paddr == A_PCLO) & allowed & ~core_prohibit;

  assign pready     = 1'b1;
  assign pwr_up_req = up_q | npd_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_q   <= '0;
      ctx_q  <= '0;
      vm_q   <= '0;
      up_q   <= 1'b0;
      npd_q  <= 1'b0;
      oslk_q <= 1'b1;
    end else begin
      if (capture) begin
        hi_q  <= core_pc[2*DATA_W-1:DATA_W];
        ctx_q <= HAS_CTX ? core_ctxid : '0;
        vm_q  <= HAS_VM ? core_vmstate : '0;
      end
      if (wr_en && paddr == A_PCTL) begin
        up_q  <= pwdata[3];
        npd_q <= pwdata[0];
      end
      if (wr_en && paddr == A_OSL)
        oslk_q <= (pwdata != '0) & pwdata[0];
    end
  end

  always_comb begin
    prdata = '0;
    if (rd_en) begin
      if (is_smp && !allowed) prdata = '0;
      else case (paddr)
        A_PCLO:  prdata = core_prohibit ? '1 : core_pc[DATA_W-1:0];
        A_CTX:   prdata = ctx_q;
        A_VM:    prdata = vm_q;
        A_PCHI:  prdata = hi_q;
        A_PCTL:  prdata = DATA_W'({up_q, 2'b00, npd_q});
        A_PSTAT: prdata = DATA_W'({core_dlock, oslk_q, 4'b0000, core_pwr_good});
        A_ID1:   prdata = DATA_W'(PC_OFFSET_MODE);
        A_ID0:   prdata = DATA_W'(SAMPLE_MODE);
        default: prdata = '0;
      endcase
    end
  end

  assert_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    capture |=> (hi_q == $past(core_pc[2*DATA_W-1:DATA_W])));
  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_en && paddr == A_PCLO) |=> $stable(hi_q) && $stable(ctx_q) && $stable(vm_q));
  assert_prohibit_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && paddr == A_PCLO && allowed && core_prohibit) |-> prdata == '1);
  assert_blocked_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && is_smp && !allowed) |-> prdata == '0);
  assert_pwrreq_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && paddr == A_PCTL) |=> pwr_up_req == ($past(pwdata[3]) | $past(pwdata[0])));
  assert_osl_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && paddr == A_OSL && pwdata == '0) |=> !oslk_q);
endmodule

// File: tb/pcsamp_dbg_regs_bench.sv
`timescale 1ns/1ps
module pcsamp_dbg_regs_bench;
  logic clk = 1'b0, rst_n = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [11:0] paddr = '0;
  logic [31:0] pwdata = '0, prdata, prdata_b;
  logic pready, pready_b, pwr_up_req, pwr_up_req_b;
  logic [63:0] core_pc = '0;
  logic [31:0] core_ctxid = '0, core_vmstate = '0;
  logic core_prohibit = 0, core_pwr_good = 1, core_dlock = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  logic [31:0] m_hi, m_ctx, m_vm;
  logic m_up, m_npd, m_oslk;

  always #4 clk = ~clk;

  pcsamp_dbg_regs u_pcsamp_dbg_regs (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata, .pready,
    .core_pc, .core_ctxid, .core_vmstate, .core_prohibit, .core_pwr_good, .core_dlock,
    .pwr_up_req);

  pcsamp_dbg_regs #(.SAMPLE_MODE(4'd1), .PC_OFFSET_MODE(4'd2)) u_pcsamp_dbg_regs_pconly (
    .clk, .rst_n, .psel, .penable, .pwrite, .paddr, .pwdata, .prdata(prdata_b), .pready(pready_b),
    .core_pc, .core_ctxid, .core_vmstate, .core_prohibit, .core_pwr_good, .core_dlock,
    .pwr_up_req(pwr_up_req_b));

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %08h expected %08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [11:0] a, input bit full);
    bit ok = core_pwr_good && !core_dlock;
    case (a)
      12'h0A0: return !ok ? 32'h0 : core_prohibit ? 32'hFFFFFFFF : core_pc[31:0];
      12'h0A4: return (ok && full) ? m_ctx : 32'h0;
      12'h0A8: return (ok && full) ? m_vm : 32'h0;
      12'h0AC: return ok ? m_hi : 32'h0;
      12'h310: return {28'h0, m_up, 2'b00, m_npd};
      12'h314: return {25'h0, core_dlock, m_oslk, 4'h0, core_pwr_good};
      12'hFC4: return full ? 32'd1 : 32'd2;
      12'hFC8: return full ? 32'd3 : 32'd1;
      default: return 32'h0;
    endcase
  endfunction

  task automatic apb_read(input logic [11:0] a, input string req);
    logic [31:0] ea, eb;
    @(negedge clk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk); penable = 1;
    #1;
    ea = exp_rd(a, 1'b1); eb = exp_rd(a, 1'b0);
    check(req, prdata, ea);
    check(req, prdata_b, eb);
    check("R11", {31'h0, pready}, 32'h1);
    if (a == 12'h0A0 && core_pwr_good && !core_dlock && !core_prohibit) begin
      m_hi = core_pc[63:32]; m_ctx = core_ctxid; m_vm = core_vmstate;
    end
    @(posedge clk);
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk); penable = 1;
    @(posedge clk);
    if (a == 12'h310) begin m_up = d[3]; m_npd = d[0]; end
    if (a == 12'h300) m_oslk = d[0];
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic new_core(input bit hostile);
    core_pc = {$urandom, $urandom}; core_ctxid = $urandom; core_vmstate = $urandom;
    core_prohibit = hostile && ($urandom_range(0, 3) == 0);
    core_pwr_good = !hostile || ($urandom_range(0, 3) != 0);
    core_dlock = hostile && ($urandom_range(0, 5) == 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got %08h expected %08h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [11:0] addrs [9];
    addrs = '{12'h0A0, 12'h0A4, 12'h0A8, 12'h0AC, 12'h310, 12'h314, 12'hFC4, 12'hFC8, 12'h200};
    void'($urandom(32'd2024));
    m_hi = 0; m_ctx = 0; m_vm = 0; m_up = 0; m_npd = 0; m_oslk = 1;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    // R1 reset state
    check("R1", {31'h0, pwr_up_req}, 32'h0);
    apb_read(12'h310, "R1");
    apb_read(12'h314, "R1");
    apb_read(12'h0AC, "R1");
    apb_read(12'h0A4, "R1");
    // R2 R3 directed capture, then core moves on
    core_pc = 64'h1234_5678_9ABC_DEF0; core_ctxid = 32'hC0DE_0001; core_vmstate = 32'h9000_0042;
    apb_read(12'h0A0, "R2");
    core_pc = 64'hFFFF_0000_1111_2222; core_ctxid = 32'h5; core_vmstate = 32'h6;
    apb_read(12'h0AC, "R3"); apb_read(12'h0A4, "R3"); apb_read(12'h0A8, "R3");
    check("R3", m_hi, 32'h1234_5678);
    // R4 prohibited returns ones, no capture
    core_prohibit = 1;
    apb_read(12'h0A0, "R4");
    core_prohibit = 0;
    apb_read(12'h0AC, "R4");
    // R5 unpowered / double-locked
    core_pwr_good = 0;
    apb_read(12'h0A0, "R5"); apb_read(12'h0A4, "R5");
    core_pwr_good = 1; core_dlock = 1;
    apb_read(12'h0A0, "R5"); apb_read(12'h0AC, "R5"); apb_read(12'h314, "R7");
    core_dlock = 0;
    apb_read(12'h0A4, "R5");
    // R6 power request
    apb_write(12'h310, 32'hFFFF_FFF6);
    #1 check("R6", {31'h0, pwr_up_req}, 32'h0);
    apb_read(12'h310, "R6");
    apb_write(12'h310, 32'h0000_0008);
    #1 check("R6", {31'h0, pwr_up_req}, 32'h1);
    apb_write(12'h310, 32'h0000_0001);
    #1 check("R6", {31'h0, pwr_up_req}, 32'h1);
    apb_read(12'h310, "R6");
    // R8 OS lock
    apb_write(12'h300, 32'h0);
    apb_read(12'h314, "R8");
    apb_write(12'h300, 32'h1);
    apb_read(12'h314, "R8");
    apb_read(12'h300, "R8");
    // R9 ID registers ignore writes
    apb_write(12'hFC8, 32'hFFFF_FFFF); apb_write(12'hFC4, 32'h0);
    apb_read(12'hFC8, "R9"); apb_read(12'hFC4, "R9");
    // R10 gated registers on PC-only instance (checked via prdata_b)
    apb_read(12'h0A0, "R10"); apb_read(12'h0A8, "R10");
    // R11 unmapped
    apb_read(12'h200, "R11");
    // random mix
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      new_core($urandom_range(0, 1) == 1);
      if (op < 7) apb_read(addrs[$urandom_range(0, 8)], "R2");
      else if (op == 7) apb_write(12'h310, $urandom);
      else if (op == 8) apb_write(12'h300, ($urandom_range(0, 1) == 1) ? 32'h0 : $urandom);
      else apb_read(12'h0A0, "R3");
      #1 check("R6", {31'h0, pwr_up_req}, {31'h0, m_up | m_npd});
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule